// File: doc/BRIEF.md
# HDR Compressed Texture Tile Decoder

This block expands compressed high-dynamic-range texture tiles into half-precision RGB pixels. A tile covers 4x4 pixels and arrives as one 128-bit word, which is 8 bits per pixel, through a valid/ready handshake. Each decoded pixel is 48 bits wide: three 16-bit half-precision floats for red, green and blue. The decoder emits one 2x2 quad of four pixels per clock, so a tile leaves in four consecutive cycles.

Per-pixel luminance is rebuilt from a shared tile base and a 4-bit per-pixel code. Red and blue chroma weights are stored once per quad. Green is rebuilt as unity minus red minus blue. Each channel value is the luminance times its weight, rounded once to half precision. A small issue state machine holds the accepted tile and feeds one quad per cycle into a three-stage pipeline. The first stage rebuilds luminance and green. The second forms the exact integer products. The third normalises and rounds them to half precision.

The issue machine has two states. IDLE waits with ready high. ISSUE steps a quad counter through 0..3. The transitions are:
- IDLE to ISSUE on acceptance.
- ISSUE to ISSUE while quads remain, or with a reload when a new tile is accepted as the last quad issues.
- ISSUE to IDLE at the last quad when no tile is offered.

Top module: `hdr_tile_decoder`

## Requirements
- R1: `in_ready` is 1 in IDLE and in the cycle the fourth quad of the current tile issues, and 0 in the other three issue cycles. A tile is taken only at a rising edge with `in_valid` and `in_ready` both high. A tile offered while `in_ready` is 0 is not taken until `in_ready` returns.
- R2: A tile accepted at edge k produces quads 0,1,2,3 after edges k+3, k+4, k+5 and k+6, with `out_valid` high and `out_quad` equal to the quad number. Quad 0 is top-left, 1 top-right, 2 bottom-left, 3 bottom-right.
- R3: Tile layout. Bits [127:120] hold the 8-bit base. Quad q's 30-bit record sits at bits [119-30q -: 30]. A record is red [29:23], blue [22:16], then four 4-bit codes from bits [15:12] down to [3:0], for the quad's pixels in raster order (top-left, top-right, bottom-left, bottom-right).
- R4: Pixel luminance is the base shifted left by 4 plus the pixel's code, a 12-bit integer from 0 to 4095.
- R5: Chroma weights are unsigned with 7 fractional bits, so the value 128 is 1.0. Green is 128 - red - blue, and it is 0 when red + blue exceeds 128.
- R6: Each channel is the IEEE half-precision value of luminance x weight / 128, rounded to nearest with ties to even. Pixel p of the quad occupies `out_pix[48p+47:48p]`, with red in [47:32], green in [31:16] and blue in [15:0].
- R7: A zero luminance or zero weight gives +0 (0x0000), and no output field is ever subnormal.
- R8: Tiles offered back to back stream without bubbles: `out_valid` stays high for 4N consecutive cycles for N tiles.
- R9: While `rst_n` is 0, `in_ready` is 1 and `out_valid` is 0.
- R10: `out_valid` is 0 whenever no accepted quad is due.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A compressed tile is offered |
| in_ready | output | 1 | Decoder can take a tile at this edge |
| in_tile | input | 128 | Compressed tile word |
| out_valid | output | 1 | `out_quad` and `out_pix` carry a decoded quad |
| out_quad | output | 2 | Index of the quad being emitted |
| out_pix | output | 192 | Four decoded 48-bit pixels |

## Verification
Quad q of a tile accepted at rising edge k is due on the outputs just after edge k+3+q. The driver records the cycle count of the accepting edge and pushes the four expected quads into the scoreboard, each stamped with its due cycle. The monitor samples on the falling edge and compares cycle, quad index and pixels. Output that arrives early, late, never or without a pending item is reported, so the latency and no-bubble rules are checked on every tile, not only on the data.

// File: rtl/hdr_dec_pkg.sv
package hdr_dec_pkg;

    localparam int TILE_W   = 128;
    localparam int BASE_W   = 8;
    localparam int CODE_W   = 4;
    localparam int CHR_W    = 7;
    localparam int CHR_FRAC = 7;
    localparam int QUADS    = 4;
    localparam int QPIX     = 4;
    localparam int CHAN     = 3;

    localparam int LUM_W    = BASE_W + CODE_W;
    localparam int GRN_W    = CHR_W + 1;
    localparam int REC_W    = 2 * CHR_W + QPIX * CODE_W;
    localparam int QIDX_W   = $clog2(QUADS);
    localparam int PROD_W   = LUM_W + GRN_W;

    localparam int HALF_W   = 16;
    localparam int HEXP_W   = 5;
    localparam int HMAN_W   = 10;
    localparam int HBIAS    = 15;
    localparam int PIX_W    = CHAN * HALF_W;
    localparam int QUAD_W   = QPIX * PIX_W;

    typedef enum logic {
        ST_IDLE,
        ST_ISSUE
    } iss_state_t;

    typedef struct packed {
        logic [CHR_W-1:0]                 red;
        logic [CHR_W-1:0]                 blue;
        logic [QPIX-1:0][CODE_W-1:0]      codes;
    } quad_rec_t;

    // Exact fixed-point product (CHR_FRAC fraction bits) to half precision,
    // round to nearest even. The operand range keeps results normal.
    function automatic logic [HALF_W-1:0] fx_to_half(input logic [PROD_W-1:0] fx);
        int                     msb;
        int                     ex;
        logic [PROD_W-1:0]      norm;
        logic [HMAN_W:0]        keep;
        logic                   guard;
        logic                   sticky;
        logic [HMAN_W+1:0]      sum;
        logic [HMAN_W-1:0]      mant;
        msb = 0;
        for (int i = 0; i < PROD_W; i++) begin
            if (fx[i]) msb = i;
        end
        norm   = fx << (PROD_W - 1 - msb);
        keep   = norm[PROD_W-1 -: HMAN_W+1];
        guard  = norm[PROD_W-HMAN_W-2];
        sticky = |norm[PROD_W-HMAN_W-3:0];
        sum    = {1'b0, keep} + (HMAN_W+2)'(guard & (sticky | keep[0]));
        ex     = msb - CHR_FRAC + HBIAS;
        if (sum[HMAN_W+1]) begin
            ex   = ex + 1;
            mant = sum[HMAN_W:1];
        end else begin
            mant = sum[HMAN_W-1:0];
        end
        if (fx == '0) begin
            return '0;
        end
        return {1'b0, ex[HEXP_W-1:0], mant};
    endfunction

endpackage

// File: rtl/hdr_issue_fsm.sv
module hdr_issue_fsm
    import hdr_dec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [TILE_W-1:0]     in_tile,
    output logic                  in_ready,
    output logic                  iss_valid,
    output logic [QIDX_W-1:0]     iss_idx,
    output logic [BASE_W-1:0]     iss_base,
    output quad_rec_t             iss_rec
);

    localparam logic [QIDX_W-1:0] LAST_Q = QIDX_W'(QUADS - 1);

    iss_state_t          state_q;
    iss_state_t          state_d;
    logic [TILE_W-1:0]   tile_q;
    logic [QIDX_W-1:0]   qcnt_q;
    logic                take;
    int                  rec_lsb;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Held tile and quad counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tile_q <= '0;
            qcnt_q <= '0;
        end else if (take) begin
            tile_q <= in_tile;
            qcnt_q <= '0;
        end else if (state_q == ST_ISSUE) begin
            qcnt_q <= qcnt_q + 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        iss_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                iss_valid = 1'b1;
                in_ready  = (qcnt_q == LAST_Q);
                if (qcnt_q == LAST_Q && !in_valid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        take = in_valid && in_ready;
    end

    assign rec_lsb  = TILE_W - BASE_W - REC_W * (int'(qcnt_q) + 1);
    assign iss_idx  = qcnt_q;
    assign iss_base = tile_q[TILE_W-1 -: BASE_W];
    assign iss_rec  = quad_rec_t'(tile_q[rec_lsb +: REC_W]);

    // R1
    accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (iss_valid && iss_idx == '0));

    // R2
    issue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_idx != LAST_Q) |=> (iss_valid && iss_idx == $past(iss_idx) + 1'b1));

endmodule

// File: rtl/hdr_lum_stage.sv
module hdr_lum_stage
    import hdr_dec_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            iss_valid,
    input  logic [QIDX_W-1:0]               iss_idx,
    input  logic [BASE_W-1:0]               iss_base,
    input  quad_rec_t                       iss_rec,
    output logic                            s1_valid,
    output logic [QIDX_W-1:0]               s1_idx,
    output logic [QPIX-1:0][LUM_W-1:0]      s1_lum,
    output logic [CHAN-1:0][GRN_W-1:0]      s1_chr
);

    localparam logic [GRN_W-1:0] UNITY = GRN_W'(1 << CHR_FRAC);

    logic [GRN_W-1:0]               rb_sum;
    logic [GRN_W-1:0]               green;
    logic [QPIX-1:0][LUM_W-1:0]     lum;

    always_comb begin
        rb_sum = GRN_W'(iss_rec.red) + GRN_W'(iss_rec.blue);
        green  = (rb_sum > UNITY) ? '0 : (UNITY - rb_sum);
    end

    for (genvar p = 0; p < QPIX; p++) begin : g_pix
        assign lum[p] = (LUM_W'(iss_base) << CODE_W) + LUM_W'(iss_rec.codes[QPIX-1-p]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_idx   <= '0;
            s1_lum   <= '0;
            s1_chr   <= '0;
        end else begin
            s1_valid  <= iss_valid;
            s1_idx    <= iss_idx;
            s1_lum    <= lum;
            s1_chr[2] <= GRN_W'(iss_rec.red);
            s1_chr[1] <= green;
            s1_chr[0] <= GRN_W'(iss_rec.blue);
        end
    end

    // R5
    green_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_chr[1] != '0) |->
        ((9'(s1_chr[2]) + 9'(s1_chr[1]) + 9'(s1_chr[0])) == 9'(UNITY)));

endmodule

// File: rtl/hdr_mul_stage.sv
module hdr_mul_stage
    import hdr_dec_pkg::*;
(
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    s1_valid,
    input  logic [QIDX_W-1:0]                       s1_idx,
    input  logic [QPIX-1:0][LUM_W-1:0]              s1_lum,
    input  logic [CHAN-1:0][GRN_W-1:0]              s1_chr,
    output logic                                    s2_valid,
    output logic [QIDX_W-1:0]                       s2_idx,
    output logic [QPIX-1:0][CHAN-1:0][PROD_W-1:0]   s2_prod
);

    logic [QPIX-1:0][CHAN-1:0][PROD_W-1:0] prod;

    for (genvar p = 0; p < QPIX; p++) begin : g_pix
        for (genvar c = 0; c < CHAN; c++) begin : g_chan
            assign prod[p][c] = PROD_W'(s1_lum[p]) * PROD_W'(s1_chr[c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_idx   <= '0;
            s2_prod  <= '0;
        end else begin
            s2_valid <= s1_valid;
            s2_idx   <= s1_idx;
            s2_prod  <= prod;
        end
    end

    // R7
    zero_lum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_lum[0] == '0) |=> (s2_prod[0] == '0));

endmodule

// File: rtl/hdr_pack_stage.sv
module hdr_pack_stage
    import hdr_dec_pkg::*;
(
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    s2_valid,
    input  logic [QIDX_W-1:0]                       s2_idx,
    input  logic [QPIX-1:0][CHAN-1:0][PROD_W-1:0]   s2_prod,
    output logic                                    out_valid,
    output logic [QIDX_W-1:0]                       out_quad,
    output logic [QUAD_W-1:0]                       out_pix
);

    logic [QUAD_W-1:0] packed_d;

    for (genvar p = 0; p < QPIX; p++) begin : g_pix
        for (genvar c = 0; c < CHAN; c++) begin : g_chan
            assign packed_d[p*PIX_W + c*HALF_W +: HALF_W] = fx_to_half(s2_prod[p][c]);

            // R7
            no_subnormal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_pix[p*PIX_W + c*HALF_W + HMAN_W +: HEXP_W] == '0) |->
                (out_pix[p*PIX_W + c*HALF_W +: HMAN_W] == '0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_quad  <= '0;
            out_pix   <= '0;
        end else begin
            out_valid <= s2_valid;
            out_quad  <= s2_idx;
            out_pix   <= packed_d;
        end
    end

endmodule

// File: rtl/hdr_tile_decoder.sv
module hdr_tile_decoder
    import hdr_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [127:0]    in_tile,
    output logic            out_valid,
    output logic [1:0]      out_quad,
    output logic [191:0]    out_pix
);

    logic                                   iss_valid;
    logic [QIDX_W-1:0]                      iss_idx;
    logic [BASE_W-1:0]                      iss_base;
    quad_rec_t                              iss_rec;
    logic                                   s1_valid;
    logic [QIDX_W-1:0]                      s1_idx;
    logic [QPIX-1:0][LUM_W-1:0]             s1_lum;
    logic [CHAN-1:0][GRN_W-1:0]             s1_chr;
    logic                                   s2_valid;
    logic [QIDX_W-1:0]                      s2_idx;
    logic [QPIX-1:0][CHAN-1:0][PROD_W-1:0]  s2_prod;

    hdr_issue_fsm u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_tile   (in_tile),
        .in_ready  (in_ready),
        .iss_valid (iss_valid),
        .iss_idx   (iss_idx),
        .iss_base  (iss_base),
        .iss_rec   (iss_rec)
    );

    hdr_lum_stage u_lum (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_idx   (iss_idx),
        .iss_base  (iss_base),
        .iss_rec   (iss_rec),
        .s1_valid  (s1_valid),
        .s1_idx    (s1_idx),
        .s1_lum    (s1_lum),
        .s1_chr    (s1_chr)
    );

    hdr_mul_stage u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_idx    (s1_idx),
        .s1_lum    (s1_lum),
        .s1_chr    (s1_chr),
        .s2_valid  (s2_valid),
        .s2_idx    (s2_idx),
        .s2_prod   (s2_prod)
    );

    hdr_pack_stage u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .s2_valid  (s2_valid),
        .s2_idx    (s2_idx),
        .s2_prod   (s2_prod),
        .out_valid (out_valid),
        .out_quad  (out_quad),
        .out_pix   (out_pix)
    );

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ##3 (out_valid && out_quad == $past(iss_idx, 3)));

    // R2
    out_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_quad != 2'd3) |=> (out_valid && out_quad == $past(out_quad) + 2'd1));

endmodule

// File: tb/hdr_tile_decoder_tb.sv
module hdr_tile_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [127:0]   in_tile = '0;
    logic           in_ready;
    logic           out_valid;
    logic [1:0]     out_quad;
    logic [191:0]   out_pix;

    typedef struct {
        int             due;
        logic [1:0]     q;
        logic [191:0]   pix;
    } exp_t;

    exp_t   sb[$];
    int     n_chk = 0;
    int     n_bad = 0;
    int     cyc = 0;
    bit     done = 1'b0;

    hdr_tile_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_tile   (in_tile),
        .out_valid (out_valid),
        .out_quad  (out_quad),
        .out_pix   (out_pix)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Half-precision value of p/128, nearest-even, computed with reals (R6)
    function automatic logic [15:0] ref_half(input int p);
        real x;
        real s;
        real fr;
        int  e;
        int  f;
        if (p == 0) return 16'h0000;
        x = real'(p) / 128.0;
        e = 0;
        while (x >= 2.0) begin x = x / 2.0; e++; end
        while (x < 1.0)  begin x = x * 2.0; e--; end
        s  = x * 1024.0;
        f  = $rtoi(s);
        fr = s - real'(f);
        if (fr > 0.5 || (fr == 0.5 && (f % 2) == 1)) f++;
        if (f == 2048) begin f = 1024; e++; end
        return {1'b0, 5'(e + 15), 10'(f - 1024)};
    endfunction

    // Expected quad from the tile layout of R3, R4, R5, R6
    function automatic logic [191:0] ref_quad(input logic [127:0] t, input int q);
        logic [29:0]  rec;
        logic [191:0] pix;
        int base, r, b, g, code, lum;
        base = int'(t[127:120]);
        rec  = t[119 - 30*q -: 30];
        r    = int'(rec[29:23]);
        b    = int'(rec[22:16]);
        g    = 128 - r - b;
        if (g < 0) g = 0;
        pix = '0;
        for (int p = 0; p < 4; p++) begin
            code = int'(rec[15 - 4*p -: 4]);
            lum  = base * 16 + code;
            pix[48*p +: 48] = {ref_half(lum * r), ref_half(lum * g), ref_half(lum * b)};
        end
        return pix;
    endfunction

    function automatic logic [127:0] mk_tile(input int base, input int r[4], input int b[4],
                                             input int c[16]);
        logic [127:0] t;
        t = '0;
        t[127:120] = 8'(base);
        for (int q = 0; q < 4; q++) begin
            t[119 - 30*q -: 7]      = 7'(r[q]);
            t[112 - 30*q -: 7]      = 7'(b[q]);
            for (int p = 0; p < 4; p++) begin
                t[105 - 30*q - 4*p -: 4] = 4'(c[4*q + p]);
            end
        end
        return t;
    endfunction

    // Driver: called at a falling edge; pushes four expected quads (R2)
    task automatic send(input logic [127:0] t);
        int acc;
        exp_t it;
        in_valid = 1'b1;
        in_tile  = t;
        while (!in_ready) @(negedge clk);
        acc = cyc + 1;
        for (int q = 0; q < 4; q++) begin
            it.due = acc + 3 + q;
            it.q   = 2'(q);
            it.pix = ref_quad(t, q);
            sb.push_back(it);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        exp_t it;
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "spurious out_valid", 192'(out_quad), 192'(0));
                end else begin
                    it = sb.pop_front();
                    check(cyc == it.due, "R2", "quad arrival cycle", 192'(cyc), 192'(it.due));
                    check(out_quad == it.q, "R2", "quad index", 192'(out_quad), 192'(it.q));
                    check(out_pix == it.pix, "R6", "quad pixels", out_pix, it.pix);
                end
            end else if (sb.size() > 0 && sb[0].due <= cyc) begin
                it = sb.pop_front();
                check(1'b0, "R8", "expected quad missing", 192'(cyc), 192'(it.due));
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int r[4];
        int b[4];
        int c[16];
        logic [127:0] tile_a;
        logic [127:0] tile_b;
        logic [127:0] tile_max;

        // R9: reset state
        repeat (3) @(negedge clk);
        check(in_ready === 1'b1, "R9", "in_ready in reset", 192'(in_ready), 192'(1));
        check(out_valid === 1'b0, "R9", "out_valid in reset", 192'(out_valid), 192'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1, "R1", "in_ready idle", 192'(in_ready), 192'(1));

        // R6 model anchors: ties to even and exact values
        check(ref_half(262272) == 16'h6800, "R6", "tie rounds to even", 192'(ref_half(262272)), 192'(16'h6800));
        check(ref_half(262528) == 16'h6802, "R6", "tie rounds up", 192'(ref_half(262528)), 192'(16'h6802));
        check(ref_half(32512) == 16'h5BF0, "R6", "exact 254.0", 192'(ref_half(32512)), 192'(16'h5BF0));

        // Tile A: ties (R6), green saturation (R5), layout (R3, R4)
        r = '{0, 100, 64, 127};
        b = '{0, 100, 32, 1};
        c = '{1, 3, 0, 15,  2, 4, 6, 8,  9, 10, 11, 12,  5, 7, 13, 14};
        tile_a = mk_tile(128, r, b, c);
        send(tile_a);
        // R1: ready pattern over the issue window
        check(in_ready == 1'b0, "R1", "ready low quad0", 192'(in_ready), 192'(0));
        @(negedge clk);
        check(in_ready == 1'b0, "R1", "ready low quad1", 192'(in_ready), 192'(0));
        @(negedge clk);
        check(in_ready == 1'b0, "R1", "ready low quad2", 192'(in_ready), 192'(0));
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "ready high last quad", 192'(in_ready), 192'(1));
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "ready high idle", 192'(in_ready), 192'(1));
        repeat (6) @(negedge clk);

        // R7: zero tile and zero luminance
        r = '{0, 0, 0, 0};
        b = '{0, 0, 0, 0};
        c = '{default: 0};
        send(mk_tile(0, r, b, c));
        repeat (6) @(negedge clk);

        // R4/R5: maximum fields, green saturates
        r = '{127, 127, 127, 0};
        b = '{127, 1, 0, 127};
        c = '{default: 15};
        tile_max = mk_tile(255, r, b, c);
        send(tile_max);

        // R1: tile B offered while busy is held until ready
        r = '{10, 20, 30, 40};
        b = '{50, 60, 70, 80};
        c = '{0, 1, 2, 3,  4, 5, 6, 7,  8, 9, 10, 11,  12, 13, 14, 15};
        tile_b = mk_tile(37, r, b, c);
        send(tile_a);
        send(tile_b);

        // R8: back-to-back stream of varied tiles
        for (int k = 0; k < 8; k++) begin
            send({$urandom, $urandom, $urandom, $urandom});
        end
        repeat (12) @(negedge clk);

        // R10: nothing pending, nothing emitted
        check(sb.size() == 0, "R10", "scoreboard drained", 192'(sb.size()), 192'(0));
        check(out_valid == 1'b0, "R10", "out_valid idle", 192'(out_valid), 192'(0));
        finish_run();
    end

endmodule